// File: doc/BRIEF.md
# Nine-Point Half-Pixel Interpolator

This block turns up to four neighbouring RGB565 source pixels into a single RGB565 output pixel for an image-warping datapath. The sample position it resolves is snapped in advance to one of nine points: a whole pixel, a point halfway between two pixels along x or along y, or the centre of a 2x2 square of pixels. Two flags, one per axis, state whether the position sits on a half step. The block then either forwards the anchor pixel, takes the mean of a pair, or takes the mean of all four.

The averaging is done separately on the red, green and blue fields. It uses only adders and right shifts, with no multipliers and no fractional weights. An invalid marker forces a black output, for positions that fall outside the source image. The block is one registered pipeline stage. Fetching the pixels and computing addresses are the caller's job.

The four inputs are named by their offset from the anchor:

| Input | Position |
|---|---|
| `in_p00` | (x, y) |
| `in_p10` | (x+1, y) |
| `in_p01` | (x, y+1) |
| `in_p11` | (x+1, y+1) |

Top module: `nph_interp`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_pix` is 0x0000.
- R2: `out_valid` at each clock edge takes the value that `in_valid` had at the previous edge, giving exactly one cycle of latency.
- R3: With `in_half_x`=0 and `in_half_y`=0, the result equals `in_p00` unchanged; `in_p10`, `in_p01` and `in_p11` have no effect.
- R4: With only `in_half_x`=1, each channel of the result is (p00 + p10) >> 1; `in_p01` and `in_p11` have no effect.
- R5: With only `in_half_y`=1, each channel of the result is (p00 + p01) >> 1; `in_p10` and `in_p11` have no effect.
- R6: With both flags set, each channel of the result is (p00 + p10 + p01 + p11) >> 2, truncated with no rounding (for example, red values 1,1,1,0 give 0).
- R7: The channel fields are red [15:11], green [10:5] and blue [4:0]. Each channel is averaged on its own, so no carry passes from one field into another, even when all inputs are at full scale.
- R8: When `in_invalid`=1 with `in_valid`=1, the result is 0x0000, whatever the flags and pixels are.
- R9: When `in_valid`=0, `out_pix` keeps its previous value, and the flag and pixel inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The input bundle is valid this cycle |
| in_invalid | input | 1 | The sample lies outside the source; output black |
| in_half_x | input | 1 | The x position is a half step |
| in_half_y | input | 1 | The y position is a half step |
| in_p00 | input | 16 | Anchor pixel (x, y), RGB565 |
| in_p10 | input | 16 | Pixel (x+1, y), RGB565 |
| in_p01 | input | 16 | Pixel (x, y+1), RGB565 |
| in_p11 | input | 16 | Pixel (x+1, y+1), RGB565 |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_pix | output | 16 | Interpolated pixel, RGB565 |

## Verification
A wrong mode decode shows up at the ports in the very next valid result. A pixel from the wrong neighbour, or a missing flag, changes at least one channel by more than one least-significant bit.

A sum that is too narrow, or a slice taken at the wrong offset, is caught by full-scale inputs: they either wrap to a small value or bleed a carry into the field above. A broken clock enable or valid pipe appears one cycle later, either as a changed `out_pix` while `out_valid` is low or as a result arriving on the wrong cycle. The scoreboard pairs every accepted input with exactly one result, so any such error is reported on the cycle it occurs.

// File: rtl/nph_pkg.sv
package nph_pkg;

  localparam int RED_BITS_DEF = 5;
  localparam int GRN_BITS_DEF = 6;
  localparam int BLU_BITS_DEF = 5;

  typedef enum logic [1:0] {
    MODE_ONE    = 2'd0,
    MODE_PAIR_X = 2'd1,
    MODE_PAIR_Y = 2'd2,
    MODE_QUAD   = 2'd3
  } avg_mode_e;

endpackage

// File: rtl/nph_mode_dec.sv
module nph_mode_dec
  import nph_pkg::*;
(
  input  logic      half_x,
  input  logic      half_y,
  input  logic      invalid,
  output avg_mode_e mode,
  output logic      blank
);

  always_comb begin
    unique case ({half_y, half_x})
      2'b00:   mode = MODE_ONE;
      2'b01:   mode = MODE_PAIR_X;
      2'b10:   mode = MODE_PAIR_Y;
      default: mode = MODE_QUAD;
    endcase
    blank = invalid;
  end

endmodule

// File: rtl/nph_chan_avg.sv
module nph_chan_avg
  import nph_pkg::*;
#(
  parameter int W = 5
) (
  input  avg_mode_e      mode,
  input  logic [W-1:0]   a00,
  input  logic [W-1:0]   a10,
  input  logic [W-1:0]   a01,
  input  logic [W-1:0]   a11,
  output logic [W-1:0]   y
);

  localparam int SW = W + 2;

  logic [SW-1:0] sum_x;
  logic [SW-1:0] sum_y;
  logic [SW-1:0] sum_q;

  always_comb begin
    sum_x = {2'b00, a00} + {2'b00, a10};
    sum_y = {2'b00, a00} + {2'b00, a01};
    sum_q = sum_x + {2'b00, a01} + {2'b00, a11};
    unique case (mode)
      MODE_ONE:    y = a00;
      MODE_PAIR_X: y = sum_x[W:1];
      MODE_PAIR_Y: y = sum_y[W:1];
      default:     y = sum_q[W+1:2];
    endcase
  end

endmodule

// File: rtl/nph_interp.sv
module nph_interp
  import nph_pkg::*;
#(
  parameter int RED_BITS = RED_BITS_DEF,
  parameter int GRN_BITS = GRN_BITS_DEF,
  parameter int BLU_BITS = BLU_BITS_DEF,
  parameter int PIX_W    = RED_BITS + GRN_BITS + BLU_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_invalid,
  input  logic             in_half_x,
  input  logic             in_half_y,
  input  logic [PIX_W-1:0] in_p00,
  input  logic [PIX_W-1:0] in_p10,
  input  logic [PIX_W-1:0] in_p01,
  input  logic [PIX_W-1:0] in_p11,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);

  localparam int NCH = 3;

  avg_mode_e        mode;
  logic             blank;
  logic [PIX_W-1:0] avg_pix;
  logic [PIX_W-1:0] pix_d;
  logic             pix_en;
  logic             valid_d;
  logic             valid_q;
  logic [PIX_W-1:0] pix_q;

  nph_mode_dec u_dec (
    .half_x  (in_half_x),
    .half_y  (in_half_y),
    .invalid (in_invalid),
    .mode    (mode),
    .blank   (blank)
  );

  // blue sits at the bottom, green in the middle, red at the top
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam int CW = (g == 0) ? BLU_BITS : ((g == 1) ? GRN_BITS : RED_BITS);
    localparam int LO = (g == 0) ? 0 : ((g == 1) ? BLU_BITS : BLU_BITS + GRN_BITS);
    nph_chan_avg #(.W(CW)) u_avg (
      .mode (mode),
      .a00  (in_p00[LO +: CW]),
      .a10  (in_p10[LO +: CW]),
      .a01  (in_p01[LO +: CW]),
      .a11  (in_p11[LO +: CW]),
      .y    (avg_pix[LO +: CW])
    );
  end

  always_comb begin
    valid_d = in_valid;
    pix_en  = in_valid;
    pix_d   = blank ? '0 : avg_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (pix_en) begin
        pix_q <= pix_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_pix   = pix_q;

endmodule

// File: rtl/nph_interp_chk.sv
module nph_interp_chk #(
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_invalid,
  input logic             in_half_x,
  input logic             in_half_y,
  input logic [PIX_W-1:0] in_p00,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix
);

  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (out_valid == 1'b0 && out_pix == '0)
        else $error("R1: outputs not clear in reset");
    end
  end

  assert_latency_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_latency_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_invalid && !in_half_x && !in_half_y)
      |=> (out_pix == $past(in_p00)));

  assert_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_invalid) |=> (out_pix == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_pix));

endmodule

bind nph_interp nph_interp_chk #(.PIX_W(PIX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_invalid (in_invalid),
  .in_half_x  (in_half_x),
  .in_half_y  (in_half_y),
  .in_p00     (in_p00),
  .out_valid  (out_valid),
  .out_pix    (out_pix)
);

// File: tb/sim_nph_interp.sv
`timescale 1ns/1ps
module sim_nph_interp;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_invalid = 1'b0;
  logic        in_half_x = 1'b0;
  logic        in_half_y = 1'b0;
  logic [15:0] in_p00 = '0;
  logic [15:0] in_p10 = '0;
  logic [15:0] in_p01 = '0;
  logic [15:0] in_p11 = '0;
  logic        out_valid;
  logic [15:0] out_pix;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit have_last = 1'b0;
  logic [15:0] last_pix = '0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  nph_interp u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_invalid(in_invalid),
    .in_half_x(in_half_x), .in_half_y(in_half_y),
    .in_p00(in_p00), .in_p10(in_p10), .in_p01(in_p01), .in_p11(in_p11),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  // reference built from the requirement text: fields r[15:11] g[10:5] b[4:0]
  function automatic logic [15:0] ref_pix(input bit inv, input bit hx, input bit hy,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] c, input logic [15:0] d);
    int r, g, bl;
    if (inv) return 16'h0000;
    if (!hx && !hy) return a;
    if (hx && !hy) begin
      r  = (int'(a[15:11]) + int'(b[15:11])) / 2;
      g  = (int'(a[10:5])  + int'(b[10:5]))  / 2;
      bl = (int'(a[4:0])   + int'(b[4:0]))   / 2;
    end else if (!hx && hy) begin
      r  = (int'(a[15:11]) + int'(c[15:11])) / 2;
      g  = (int'(a[10:5])  + int'(c[10:5]))  / 2;
      bl = (int'(a[4:0])   + int'(c[4:0]))   / 2;
    end else begin
      r  = (int'(a[15:11]) + int'(b[15:11]) + int'(c[15:11]) + int'(d[15:11])) / 4;
      g  = (int'(a[10:5])  + int'(b[10:5])  + int'(c[10:5])  + int'(d[10:5]))  / 4;
      bl = (int'(a[4:0])   + int'(b[4:0])   + int'(c[4:0])   + int'(d[4:0]))   / 4;
    end
    return {r[4:0], g[5:0], bl[4:0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: applies one bundle for one cycle and records the expected result
  task automatic drive(input string req, input bit v, input bit inv, input bit hx, input bit hy,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] c, input logic [15:0] d,
      input logic [15:0] exp);
    @(negedge clk);
    in_valid = v; in_invalid = inv; in_half_x = hx; in_half_y = hy;
    in_p00 = a; in_p10 = b; in_p01 = c; in_p11 = d;
    if (v) begin
      exp_q.push_back(exp);
      tag_q.push_back(req);
    end
  endtask

  task automatic drive_ref(input string req, input bit inv, input bit hx, input bit hy,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] c, input logic [15:0] d);
    drive(req, 1'b1, inv, hx, hy, a, b, c, d, ref_pix(inv, hx, hy, a, b, c, d));
  endtask

  task automatic idle(input bit hx, input bit hy, input logic [15:0] a);
    drive("R9", 1'b0, 1'b0, hx, hy, a, ~a, a ^ 16'h5A5A, 16'h1234, 16'h0000);
  endtask

  // monitor: samples just after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2: actual out_valid 1 expected 0 (no pending input)");
        end else begin
          string t;
          logic [15:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, out_pix, e);
          last_pix = e;
          have_last = 1'b1;
        end
      end else begin
        if (exp_q.size() != 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2: actual out_valid 0 expected 1");
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
        if (have_last) check("R9", out_pix, last_pix);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", {15'd0, out_valid}, 16'd0);
    check("R1", out_pix, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    // R3 pass through, other pixels ignored
    drive("R3", 1, 0, 0, 0, 16'hABCD, 16'hFFFF, 16'h0000, 16'h1111, 16'hABCD);
    drive("R3", 1, 0, 0, 0, 16'h0001, 16'h8000, 16'h7FFF, 16'hFFFF, 16'h0001);
    // R4 pair along x: red 31+30 -> 30, green 0+63 -> 31, blue 1+2 -> 1
    drive("R4", 1, 0, 1, 0, {5'd31, 6'd0, 5'd1}, {5'd30, 6'd63, 5'd2}, 16'hFFFF, 16'hFFFF,
          {5'd30, 6'd31, 5'd1});
    // R5 pair along y, p10 and p11 ignored
    drive("R5", 1, 0, 0, 1, {5'd4, 6'd10, 5'd7}, 16'hFFFF, {5'd6, 6'd11, 5'd8}, 16'hFFFF,
          {5'd5, 6'd10, 5'd7});
    // R6 truncation: red 1,1,1,0 -> 0; green 3,3,3,2 -> 2; blue 31x4 -> 31
    drive("R6", 1, 0, 1, 1, {5'd1, 6'd3, 5'd31}, {5'd1, 6'd3, 5'd31}, {5'd1, 6'd3, 5'd31},
          {5'd0, 6'd2, 5'd31}, {5'd0, 6'd2, 5'd31});
    // R7 full scale and cross-field patterns
    drive("R7", 1, 0, 1, 1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    drive("R7", 1, 0, 1, 0, 16'hF800, 16'h07FF, 16'h0000, 16'h0000, 16'h7BEF);
    drive("R7", 1, 0, 0, 1, 16'h07E0, 16'hFFFF, 16'hF81F, 16'h0000, 16'h7BEF);
    // R8 invalid forces black for every flag pattern
    drive("R8", 1, 1, 0, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000);
    drive("R8", 1, 1, 1, 1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000);
    // R9 hold: a known value then several idle cycles with busy inputs
    drive("R3", 1, 0, 0, 0, 16'h1357, 16'h0, 16'h0, 16'h0, 16'h1357);
    idle(1, 1, 16'hFFFF);
    idle(0, 0, 16'h0F0F);
    idle(1, 0, 16'hAAAA);
    // R2 back-to-back and gapped traffic
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a, b, c, d;
      bit inv, hx, hy;
      a = 16'($urandom); b = 16'($urandom); c = 16'($urandom); d = 16'($urandom);
      inv = ($urandom % 8) == 0; hx = 1'($urandom); hy = 1'($urandom);
      if (($urandom % 4) == 0) idle(hx, hy, a);
      else drive_ref(inv ? "R8" : (hx && hy ? "R6" : (hx ? "R4" : (hy ? "R5" : "R3"))),
                     inv, hx, hy, a, b, c, d);
    end
    idle(0, 0, 16'h0);
    idle(0, 0, 16'h0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2: actual %0d results missing expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R2: actual watchdog expired expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule